// File: doc/BRIEF.md
# Three-Wire Attenuator Command Transmitter

This block is the controller-side sender for a write-only three-wire link to an attenuator: a serial data line, a serial clock line and a frame strobe that is active low. A client hands over an 8-bit address and an 8-bit attenuation code through a valid/ready handshake. The block then pulls the strobe low and waits a programmable setup time. It clocks out the sixteen bits with data changing only while the serial clock is low, and raises the strobe again so that the receiver commits the word.

All link timing is counted in system clocks. One parameter sets the setup gap between the strobe falling and the first serial clock rise. A second sets the high and low half-periods of the serial clock. A third sets how long the strobe must stay high before a new frame may begin. The default values give at least 150 ns of setup at a 125 MHz system clock. The serial clock idles low and is never low-to-high-to-low around the strobe's falling edge, so no stray falling clock edge can land after the strobe drops.

Top module: `atten_link_tx`

## Requirements
- R1: After reset and whenever idle, the strobe is high, the serial clock is low, the serial data is low, `req_ready` is 1 and `busy` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle the strobe is low, `busy` is 1 and `req_ready` is 0.
- R3: The first rising edge of the serial clock comes exactly SETUP_CYC system clocks after the strobe falls. The serial clock stays low during that gap.
- R4: A frame has exactly 16 rising serial clock edges. The data line at each rising edge carries, in order, address bits 7 down to 0 and then code bits 7 down to 0. Any address value, zero or not, is sent as given.
- R5: Each high and each low phase of the serial clock lasts HALF_CYC system clocks. The data line changes only in the cycle in which the serial clock goes low and is stable while it is high.
- R6: The strobe rises HALF_CYC system clocks after the 16th falling edge of the serial clock, with the serial clock low and the data line back at 0. The serial clock is never high while the strobe is high.
- R7: `req_ready` returns to 1, and `busy` to 0, exactly HOLD_CYC system clocks after the strobe rises.
- R8: A request presented while `busy` is 1 is neither sent nor queued. It does not alter the frame in progress. A request still held valid when the block turns idle is taken at that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 8 | Address byte, sent first |
| req_code | input | 8 | Attenuation code byte, sent second |
| busy | output | 1 | Frame or strobe hold in progress |
| lnk_sdat | output | 1 | Serial data line |
| lnk_sclk | output | 1 | Serial clock line, idles low |
| lnk_strobe | output | 1 | Frame strobe, low for the whole frame, idles high |

## Verification
The bench builds the block with SETUP_CYC=3, HALF_CYC=2 and HOLD_CYC=2. This keeps a frame near seventy cycles, so several frames fit in a short run. The small values still separate the three timings, so an off-by-one in any of the setup gap, the half-period or the strobe hold shows up at a distinct cycle. An even half-period of 2 checks that each phase is counted in full rather than in a single cycle. Holding a request across the end of a frame, and pulsing one in the middle of a frame, test the acceptance and rejection paths at the idle boundary.

// File: rtl/atten_link_pkg.sv
package atten_link_pkg;

    // Frame layout
    localparam int ADDR_BITS = 8;
    localparam int CODE_BITS = 8;
    localparam int WORD_BITS = ADDR_BITS + CODE_BITS;

    // Default timing for a 125 MHz system clock
    localparam int SYS_CLK_PS    = 8000;
    localparam int MIN_SETUP_PS  = 150000;
    localparam int DEF_SETUP_CYC = (MIN_SETUP_PS + SYS_CLK_PS - 1) / SYS_CLK_PS + 1;
    localparam int DEF_HALF_CYC  = 4;
    localparam int DEF_HOLD_CYC  = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_LOW,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [ADDR_BITS-1:0] addr;
        logic [CODE_BITS-1:0] code;
    } cmd_t;

    // Address byte leads, most significant bit at the top
    function automatic logic [WORD_BITS-1:0] cmd_word(input cmd_t c);
        return {c.addr, c.code};
    endfunction

    // Counter width able to hold the largest of three cycle counts
    function automatic int cnt_bits(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/atten_link_timer.sv
module atten_link_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/atten_link_shreg.sv
module atten_link_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         sdat
);

    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_word;
        end else if (shift) begin
            sr <= {sr[W-2:0], 1'b0};
        end
    end

    assign sdat = sr[W-1];

endmodule

// File: rtl/atten_link_seq.sv
module atten_link_seq
    import atten_link_pkg::*;
#(
    parameter int SETUP_CYC = 20,
    parameter int HALF_CYC  = 4,
    parameter int HOLD_CYC  = 4,
    parameter int NBITS     = 16,
    parameter int CNT_W     = 5,
    parameter int BIT_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             sr_load,
    output logic             sr_shift,
    output logic             ready,
    output logic             strobe,
    output logic             sclk
);

    phase_e           ph;
    logic [BIT_W-1:0] falls;
    logic             accept;
    logic             frame_done;

    assign ready      = (ph == PH_IDLE);
    assign accept     = req_valid && ready;
    assign frame_done = (falls == BIT_W'(NBITS));

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        sr_load  = accept;
        sr_shift = 1'b0;
        unique case (ph)
            PH_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(SETUP_CYC - 1);
                end
            end
            PH_SETUP: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HALF_CYC - 1);
                end
            end
            PH_HIGH: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HALF_CYC - 1);
                    sr_shift = 1'b1;
                end
            end
            PH_LOW: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = frame_done ? CNT_W'(HOLD_CYC - 1) : CNT_W'(HALF_CYC - 1);
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            strobe <= 1'b1;
            sclk   <= 1'b0;
            falls  <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (accept) begin
                        ph     <= PH_SETUP;
                        strobe <= 1'b0;
                        falls  <= '0;
                    end
                end
                PH_SETUP: begin
                    if (tmr_expired) begin
                        ph   <= PH_HIGH;
                        sclk <= 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (tmr_expired) begin
                        ph    <= PH_LOW;
                        sclk  <= 1'b0;
                        falls <= falls + BIT_W'(1);
                    end
                end
                PH_LOW: begin
                    if (tmr_expired) begin
                        if (frame_done) begin
                            ph     <= PH_HOLD;
                            strobe <= 1'b1;
                        end else begin
                            ph   <= PH_HIGH;
                            sclk <= 1'b1;
                        end
                    end
                end
                PH_HOLD: begin
                    if (tmr_expired) begin
                        ph <= PH_IDLE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R6: serial clock only pulses inside a frame
    a_r6_clock_inside_frame: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !strobe);

    // R8: while not idle, a valid request never restarts the sequence
    a_r8_no_restart_busy: assert property (@(posedge clk) disable iff (rst)
        (!ready && req_valid) |-> !sr_load);

endmodule

// File: rtl/atten_link_tx.sv
module atten_link_tx
    import atten_link_pkg::*;
#(
    parameter int SETUP_CYC = DEF_SETUP_CYC,
    parameter int HALF_CYC  = DEF_HALF_CYC,
    parameter int HOLD_CYC  = DEF_HOLD_CYC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_BITS-1:0] req_addr,
    input  logic [CODE_BITS-1:0] req_code,
    output logic                 busy,
    output logic                 lnk_sdat,
    output logic                 lnk_sclk,
    output logic                 lnk_strobe
);

    localparam int CNT_W = cnt_bits(SETUP_CYC, HALF_CYC, HOLD_CYC);
    localparam int BIT_W = $clog2(WORD_BITS + 1);

    cmd_t             req_cmd;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             sr_load;
    logic             sr_shift;

    assign req_cmd = '{addr: req_addr, code: req_code};
    assign busy    = !req_ready;

    atten_link_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    atten_link_shreg #(
        .W (WORD_BITS)
    ) u_shreg (
        .clk       (clk),
        .rst       (rst),
        .load      (sr_load),
        .load_word (cmd_word(req_cmd)),
        .shift     (sr_shift),
        .sdat      (lnk_sdat)
    );

    atten_link_seq #(
        .SETUP_CYC (SETUP_CYC),
        .HALF_CYC  (HALF_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .NBITS     (WORD_BITS),
        .CNT_W     (CNT_W),
        .BIT_W     (BIT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .sr_load     (sr_load),
        .sr_shift    (sr_shift),
        .ready       (req_ready),
        .strobe      (lnk_strobe),
        .sclk        (lnk_sclk)
    );

    // Checker state: serial clock rises in this frame and setup gap length
    logic             chk_sclk_q;
    logic [BIT_W-1:0] chk_rises;
    logic [CNT_W:0]   chk_setup;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_sclk_q <= 1'b0;
            chk_rises  <= '0;
            chk_setup  <= '0;
        end else begin
            chk_sclk_q <= lnk_sclk;
            if (req_ready) begin
                chk_rises <= '0;
                chk_setup <= '0;
            end else begin
                if (lnk_sclk && !chk_sclk_q) chk_rises <= chk_rises + BIT_W'(1);
                if (!lnk_strobe && !lnk_sclk && chk_rises == '0)
                    chk_setup <= chk_setup + (CNT_W+1)'(1);
            end
        end
    end

    a_r1_idle_pins: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (lnk_strobe && !lnk_sclk && !lnk_sdat));

    a_r2_accept_opens_frame: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!lnk_strobe && busy));

    a_r3_setup_gap: assert property (@(posedge clk) disable iff (rst)
        (lnk_sclk && !chk_sclk_q && chk_rises == '0) |-> (chk_setup == (CNT_W+1)'(SETUP_CYC)));

    a_r4_sixteen_rises: assert property (@(posedge clk) disable iff (rst)
        $rose(lnk_strobe) |-> (chk_rises == BIT_W'(WORD_BITS)));

    a_r5_data_steady_high: assert property (@(posedge clk) disable iff (rst)
        lnk_sclk |=> (!lnk_sclk || $stable(lnk_sdat)));

    a_r6_commit_clean: assert property (@(posedge clk) disable iff (rst)
        $rose(lnk_strobe) |-> (!lnk_sclk && !lnk_sdat));

endmodule

// File: tb/tb_atten_link_tx.sv
module tb_atten_link_tx;

    localparam int S  = 3;
    localparam int H  = 2;
    localparam int D  = 2;
    localparam int NB = 16;
    localparam int FRAME_END = S + 2 * NB * H;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [7:0] req_addr = 8'h00;
    logic [7:0] req_code = 8'h00;
    logic req_ready, busy, lnk_sdat, lnk_sclk, lnk_strobe;

    always #4 clk = ~clk;

    atten_link_tx #(
        .SETUP_CYC (S),
        .HALF_CYC  (H),
        .HOLD_CYC  (D)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_code   (req_code),
        .busy       (busy),
        .lnk_sdat   (lnk_sdat),
        .lnk_sclk   (lnk_sclk),
        .lnk_strobe (lnk_strobe)
    );

    int n_run  = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: elapsed cycles since the accepting edge
    bit          m_busy = 1'b0;
    int          m_el   = 0;
    logic [15:0] m_word = '0;
    logic [15:0] expq[$];

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 1'b0;
            m_el   <= 0;
        end else if (!m_busy) begin
            if (req_valid) begin
                m_busy <= 1'b1;
                m_el   <= 0;
                m_word <= {req_addr, req_code};
                expq.push_back({req_addr, req_code});
            end
        end else begin
            if (m_el + 1 == FRAME_END + D) m_busy <= 1'b0;
            m_el <= m_el + 1;
        end
    end

    // Monitor: per-cycle comparison plus a receiver-side view of the link
    bit          cmp_on = 1'b0;
    int          cyc = 0;
    int          t_stb_fall = 0, t_rise = 0, t_fall = 0, t_stb_rise = 0;
    int          rx_n = 0;
    int          commits = 0;
    logic [15:0] rx_word = '0;
    logic        p_stb = 1'b1, p_clk = 1'b0, p_dat = 1'b0, p_rdy = 1'b1;
    logic        e_stb, e_clk, e_dat, e_rdy;
    int          idx;

    always @(negedge clk) begin
        if (cmp_on) begin
            cyc++;
            if (!m_busy) begin
                e_stb = 1'b1; e_clk = 1'b0; e_dat = 1'b0; e_rdy = 1'b1;
            end else begin
                e_stb = (m_el < FRAME_END) ? 1'b0 : 1'b1;
                e_clk = (m_el >= S && m_el < FRAME_END && ((m_el - S) % (2 * H)) < H);
                idx   = (m_el < S + H) ? 0 : 1 + (m_el - S - H) / (2 * H);
                e_dat = (idx >= NB) ? 1'b0 : m_word[NB - 1 - idx];
                e_rdy = 1'b0;
            end
            chk("R6", "strobe", lnk_strobe, e_stb);
            chk("R3", "sclk", lnk_sclk, e_clk);
            chk("R4", "sdat", lnk_sdat, e_dat);
            chk("R7", "ready", req_ready, e_rdy);
            chk("R7", "busy", busy, !e_rdy);

            if (!lnk_strobe && p_stb) begin
                t_stb_fall = cyc;
                rx_n = 0;
            end
            if (lnk_sclk && !p_clk) begin
                if (rx_n == 0) chk("R3", "setup gap", cyc - t_stb_fall, S);
                else chk("R5", "low phase", cyc - t_fall, H);
                rx_word = {rx_word[14:0], lnk_sdat};
                rx_n++;
                t_rise = cyc;
            end
            if (!lnk_sclk && p_clk) begin
                chk("R5", "high phase", cyc - t_rise, H);
                t_fall = cyc;
            end
            if (lnk_sclk && p_clk) chk("R5", "data steady while high", lnk_sdat, p_dat);
            if (lnk_strobe && !p_stb) begin
                chk("R4", "rising edges in frame", rx_n, NB);
                if (expq.size() > 0) chk("R4", "received word", rx_word, expq.pop_front());
                else chk("R8", "unexpected frame", 1, 0);
                chk("R6", "commit after last fall", cyc - t_fall, H);
                chk("R6", "data low at commit", lnk_sdat, 0);
                t_stb_rise = cyc;
                commits++;
            end
            if (req_ready && !p_rdy) chk("R7", "strobe hold", cyc - t_stb_rise, D);
            p_stb = lnk_strobe;
            p_clk = lnk_sclk;
            p_dat = lnk_sdat;
            p_rdy = req_ready;
        end
    end

    // Watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            n_fail++;
            n_run++;
            $display("FAIL R7 watchdog: ready actual=%0d expected=1", req_ready);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic send(input logic [7:0] a, input logic [7:0] c);
        req_addr  = a;
        req_code  = c;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "strobe after accept", lnk_strobe, 0);
        chk("R2", "busy after accept", busy, 1);
        chk("R2", "ready after accept", req_ready, 0);
    endtask

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst    = 1'b0;
        cmp_on = 1'b1;
        @(negedge clk);
        chk("R1", "reset strobe", lnk_strobe, 1);
        chk("R1", "reset sclk", lnk_sclk, 0);
        chk("R1", "reset sdat", lnk_sdat, 0);
        chk("R1", "reset ready", req_ready, 1);
        chk("R1", "reset busy", busy, 0);

        // R4: zero address, several code patterns, non-zero address sent as given
        send(8'h00, 8'h00); wait_idle();
        send(8'h00, 8'h3F); wait_idle();
        send(8'hA5, 8'h5A); wait_idle();
        send(8'hFF, 8'h01); wait_idle();
        chk("R1", "idle sdat between frames", lnk_sdat, 0);

        // R8: request held across the end of a frame, data changed while busy
        req_addr  = 8'h12;
        req_code  = 8'h34;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_addr = 8'h56;
        req_code = 8'h78;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();

        // R8: request pulsed mid-frame and dropped before idle is ignored
        send(8'h0F, 8'hF0);
        repeat (10) @(negedge clk);
        req_addr  = 8'h99;
        req_code  = 8'h99;
        req_valid = 1'b1;
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R8", "frames committed", commits, 7);
        chk("R8", "idle after ignored request", busy, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule